// File: doc/BRIEF.md
# Five-Source Interrupt Aggregator

This block gathers interrupt requests from five sources (a synchronous serial port, an asynchronous serial port, two timers and one external line) and merges them into a single interrupt request towards a processor. Each source has a pending bit and an enable bit. The processor line is raised whenever any source is both pending and enabled.

Software reaches the block through one 16-bit control register on a simple write-strobe bus with two byte lanes. The low byte holds the five enables. The high byte, at mirrored positions, holds write-one-to-clear commands for the pending bits. A read of the register returns the pending bits, not the enables. Timer and serial sources arrive as single-cycle pulses that latch their pending bit. The external pending bit follows the level of its input.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all enables and all pending bits are 0, `irq` is low and `reg_rdata` reads 0.
- R2: A one-cycle pulse on a timer or serial event input sets its pending bit at the next clock edge. The bit then holds until it is cleared. Bit positions: 4 synchronous serial, 3 asynchronous serial, 2 timer 2, 1 timer 1, 0 external.
- R3: Pending bit 0 takes the value that `ext_lvl` had at the previous clock edge. It is set while the input is high and clear once the input is low.
- R4: A write with `reg_be[0]` high loads the enables from `reg_wdata[4:0]`. Data bits 7:5 have no effect.
- R5: A write with `reg_be[1]` high clears every pending bit i in 4..1 for which `reg_wdata[8+i]` is 1. All other pending bits keep their value.
- R6: If an event pulse and a clear for the same bit occur in the same cycle, the bit ends up set.
- R7: `reg_rdata[4:0]` always shows the pending bits and `reg_rdata[15:5]` reads 0. The enables never appear on the read port.
- R8: `irq` is high exactly when some bit is both pending and enabled, in the same cycle that the registers hold those values.
- R9: The byte lanes are independent. A write with only `reg_be[1]` high leaves the enables unchanged. A write with only `reg_be[0]` high clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 2 | Byte-lane enables: 0 selects enables, 1 selects clears |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Pending bits in 4:0, zero above |
| sync_ser_evt | input | 1 | Synchronous serial event pulse |
| async_ser_evt | input | 1 | Asynchronous serial event pulse |
| tmr2_evt | input | 1 | Timer 2 event pulse |
| tmr1_evt | input | 1 | Timer 1 event pulse |
| ext_lvl | input | 1 | External interrupt level |
| irq | output | 1 | Combined interrupt request |

## Verification
Random cycles mix event pulses, external level changes and writes with every byte-lane combination, so that pending bits build up, are cleared and are gated in many combinations. This covers both the set/clear bookkeeping and the AND/OR combination that drives `irq`. Directed cases isolate the behaviours that random traffic rarely produces:
- a clear and a pulse on the same bit in one cycle, which separates set-wins from clear-wins;
- writes on one lane carrying ones on the other lane, which exposes any leakage between lanes;
- enable data with only bits 7:5 set, which exposes a decode wider than five bits;
- an external level held high and then released, which separates level tracking from latching.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NSRC = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_be,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        sync_ser_evt,
  input  logic        async_ser_evt,
  input  logic        tmr2_evt,
  input  logic        tmr1_evt,
  input  logic        ext_lvl,
  output logic        irq
);
  localparam int CLRB = 8;

  logic [NSRC-1:0] en_q, pend_q, evt, clr;

  assign evt = {sync_ser_evt, async_ser_evt, tmr2_evt, tmr1_evt, 1'b0};
  assign clr = (reg_wr && reg_be[1]) ? reg_wdata[CLRB +: NSRC] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (reg_wr && reg_be[0]) en_q <= reg_wdata[NSRC-1:0];
      pend_q[NSRC-1:1] <= (pend_q[NSRC-1:1] & ~clr[NSRC-1:1]) | evt[NSRC-1:1];
      pend_q[0]        <= ext_lvl;
    end
  end

  assign reg_rdata = {{(16-NSRC){1'b0}}, pend_q};
  assign irq       = |(pend_q & en_q);

  p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((reg_rdata[NSRC-1:1] & $past(evt[NSRC-1:1])) == $past(evt[NSRC-1:1])));

  p_ext_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (reg_rdata[0] == $past(ext_lvl)));

  p_clear_works_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_be[1]) |=>
      ((reg_rdata[NSRC-1:1] & $past(reg_wdata[CLRB+1 +: NSRC-1] & ~evt[NSRC-1:1])) == '0));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_be[1] && |(reg_wdata[CLRB+1 +: NSRC-1] & evt[NSRC-1:1])) |=>
      ((reg_rdata[NSRC-1:1] & $past(reg_wdata[CLRB+1 +: NSRC-1] & evt[NSRC-1:1]))
        == $past(reg_wdata[CLRB+1 +: NSRC-1] & evt[NSRC-1:1])));

  p_mask_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_be[0] && reg_wdata[NSRC-1:0] == '0) |=> !irq);

  p_lane_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_be[0]) |=> $stable(en_q));
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_be = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic [4:1]  pulse = 0;
  logic        ext = 0;
  logic        irq;
  int checks = 0, errors = 0;
  logic [4:0] m_en = 0, m_pend = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sync_ser_evt(pulse[4]), .async_ser_evt(pulse[3]),
    .tmr2_evt(pulse[2]), .tmr1_evt(pulse[1]), .ext_lvl(ext), .irq(irq));

  function automatic logic [4:0] nxt_pend(logic [4:0] p, logic wr, logic [1:0] be,
                                          logic [15:0] wd, logic [4:1] pl, logic e);
    logic [4:0] c;
    c = (wr && be[1]) ? wd[12:8] : 5'd0;
    return {(p[4:1] & ~c[4:1]) | pl, e};
  endfunction

  function automatic logic [4:0] nxt_en(logic [4:0] en, logic wr, logic [1:0] be, logic [15:0] wd);
    return (wr && be[0]) ? wd[4:0] : en;
  endfunction

  task automatic check(string tag);
    checks++;
    if (reg_rdata !== {11'd0, m_pend}) begin
      errors++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, reg_rdata, {11'd0, m_pend});
    end
    checks++;
    if (irq !== |(m_pend & m_en)) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, |(m_pend & m_en));
    end
  endtask

  task automatic step(logic wr, logic [1:0] be, logic [15:0] wd, logic [4:1] pl, logic e, string tag);
    logic [4:0] np, ne;
    @(negedge clk);
    reg_wr = wr; reg_be = be; reg_wdata = wd; pulse = pl; ext = e;
    np = nxt_pend(m_pend, wr, be, wd, pl, e);
    ne = nxt_en(m_en, wr, be, wd);
    @(posedge clk);
    #2;
    m_pend = np; m_en = ne;
    check(tag);
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    #2 check("R1 reset");
    @(negedge clk) rst_n = 1;
    #1 check("R1 after release");

    step(1, 2'b01, 16'h00E0, 4'b1111, 0, "R4 bits 7:5 ignored");
    step(0, 2'b00, 16'h0000, 4'b0000, 0, "R4 no irq");
    step(1, 2'b10, 16'h001F, 4'b0000, 0, "R9 clear lane keeps enables");
    step(1, 2'b01, 16'h1F02, 4'b0000, 0, "R9 enable lane clears nothing");
    step(0, 2'b00, 16'h0000, 4'b0000, 0, "R8 timer1 pending and enabled");
    step(1, 2'b10, 16'h0600, 4'b0010, 0, "R6 set wins over clear");
    step(1, 2'b10, 16'h1E00, 4'b0000, 0, "R5 clear pending");
    step(1, 2'b11, 16'h0001, 4'b0000, 1, "R3 ext set");
    step(0, 2'b00, 16'h0000, 4'b0000, 1, "R3 ext held");
    step(1, 2'b10, 16'h0100, 4'b0000, 1, "R3 ext level survives clear");
    step(0, 2'b00, 16'h0000, 4'b0000, 0, "R3 ext released");
    step(0, 2'b00, 16'h0000, 4'b1000, 0, "R2 sync serial pulse");
    step(0, 2'b00, 16'h0000, 4'b0000, 0, "R2 holds, R7 no enables on read");

    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], r[3:2], $urandom, r[7:4] & r[11:8], r[12] & r[13], "R2/R5/R8 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule